// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Matcher

This block watches a running calendar clock and raises a sticky alarm flag when the current time agrees with a programmed alarm time. There are three alarm registers: minute, hour and day. Each is eight bits wide. Bit 7 of each register is a "don't care" mask for that field, and bits 6:0 hold the BCD value to compare. The three mask bits together select how often the alarm fires: every minute, on a minute match, on an hour-and-minute match, or on a full day-hour-minute match.

The comparison is made only in a cycle where the update strobe is high. The timekeeper pulses this strobe for one cycle each time the seconds roll over to zero and the minute, hour and day inputs take their new values. A hit sets the flag on the following clock edge. The flag then stays set until a read-clear pulse arrives.

All pins are plain control and status signals. The block holds no data stream, so it has no valid/ready pair and applies no back-pressure. The strobe is a single-cycle event that the block always accepts.

Top module: `tod_alarm_match`

## Requirements
- R1: While reset is asserted and right after it is released, `tod_flag` is 0.
- R2: When all three mask bits (bit 7 of `alm_min`, `alm_hour`, `alm_day`) are 1, every `upd_tick` sets `tod_flag` on the next clock edge, whatever the time values are.
- R3: When the minute mask is 0 and the hour and day masks are 1, an `upd_tick` sets the flag only if `now_min` equals `alm_min[6:0]`. Hour and day are ignored.
- R4: When the minute and hour masks are 0 and the day mask is 1, an `upd_tick` sets the flag only if both minute and hour are equal. Day is ignored.
- R5: When all three masks are 0, an `upd_tick` sets the flag only if minute, hour and day are all equal.
- R6: Without `upd_tick`, matching values never raise `tod_flag`.
- R7: Once set, `tod_flag` stays 1 across later non-matching ticks. A `flag_clr` pulse with no hit in the same cycle drops it to 0 on the next edge.
- R8: If a hit on `upd_tick` and `flag_clr` occur in the same cycle, the flag is 1 after the edge.
- R9: Each alarm register has its mask in bit 7 and its BCD compare value in bits 6:0. Those 7 bits are compared with the 7-bit current field.
- R10: The mask combinations {day,hour,min} = 101, 011, 010 and 001 are treated as illegal, and a tick never sets the flag under them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_tick | input | 1 | One-cycle strobe marking a minute rollover |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 7 | Current hours, BCD |
| now_day | input | 7 | Current day, BCD |
| alm_min | input | 8 | Minute alarm: bit 7 mask, bits 6:0 BCD value |
| alm_hour | input | 8 | Hour alarm: bit 7 mask, bits 6:0 BCD value |
| alm_day | input | 8 | Day alarm: bit 7 mask, bits 6:0 BCD value |
| flag_clr | input | 1 | Read-clear pulse for the alarm flag |
| tod_flag | output | 1 | Sticky time-of-day alarm flag |

## Verification
The assertions check the flag's sequencing on every cycle:
- the flag can only rise after a tick that carried a hit;
- it holds until a clear;
- a clear without a hit drops it;
- a hit beats a simultaneous clear;
- the all-masked mode fires on each tick;
- a full match in the unmasked mode fires;
- an illegal mask set never raises it.

Whether each partial-mask mode ignores exactly the right fields, and rejects a near miss in the one field it compares, can only be shown by the bench's scenarios, which walk matching and mismatching times through every mode.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
  localparam int REG_W    = 8;
  localparam int N_FIELDS = 3;

  typedef enum logic [2:0] {
    MODE_EVERY_MIN,
    MODE_MIN,
    MODE_HR_MIN,
    MODE_FULL,
    MODE_BAD
  } alarm_mode_e;

  // m = {day_mask, hour_mask, min_mask}
  function automatic alarm_mode_e decode_mode(input logic [2:0] m);
    case (m)
      3'b111:  return MODE_EVERY_MIN;
      3'b110:  return MODE_MIN;
      3'b100:  return MODE_HR_MIN;
      3'b000:  return MODE_FULL;
      default: return MODE_BAD;
    endcase
  endfunction
endpackage

// File: rtl/tod_field_cmp.sv
module tod_field_cmp #(
  parameter int REG_W = tod_alarm_pkg::REG_W
) (
  input  logic [REG_W-1:0] alarm_reg,
  input  logic [REG_W-2:0] cur_val,
  output logic             mask,
  output logic             eq
);
  localparam int VAL_W    = REG_W - 1;
  localparam int MASK_POS = REG_W - 1;

  // Mask sits on the top bit; the BCD value fills the bits below it (R9)
  assign mask = alarm_reg[MASK_POS];
  assign eq   = (alarm_reg[VAL_W-1:0] == cur_val);
endmodule

// File: rtl/tod_mode_sel.sv
module tod_mode_sel
  import tod_alarm_pkg::*;
#(
  parameter int N_FIELDS = tod_alarm_pkg::N_FIELDS
) (
  input  logic [N_FIELDS-1:0] mask,
  input  logic [N_FIELDS-1:0] eq,
  output logic                hit
);
  alarm_mode_e mode;

  always_comb begin
    mode = decode_mode(mask);
    unique case (mode)
      MODE_EVERY_MIN: hit = 1'b1;
      MODE_MIN:       hit = eq[0];
      MODE_HR_MIN:    hit = eq[0] & eq[1];
      MODE_FULL:      hit = &eq;
      default:        hit = 1'b0;   // illegal combinations (R10)
    endcase
  end
endmodule

// File: rtl/tod_alarm_flag.sv
module tod_alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hit,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)            flag <= 1'b0;
    else if (tick && hit)  flag <= 1'b1;   // set beats clear (R8)
    else if (clr)          flag <= 1'b0;
  end

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hit) |=> flag);
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(tick && hit)) |=> !flag);
  p_tick_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(tick && hit));
endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
  import tod_alarm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd_tick,
  input  logic [6:0] now_min,
  input  logic [6:0] now_hour,
  input  logic [6:0] now_day,
  input  logic [7:0] alm_min,
  input  logic [7:0] alm_hour,
  input  logic [7:0] alm_day,
  input  logic       flag_clr,
  output logic       tod_flag
);
  localparam int VAL_W = REG_W - 1;

  logic [REG_W-1:0]    alm_arr [N_FIELDS];
  logic [VAL_W-1:0]    cur_arr [N_FIELDS];
  logic [N_FIELDS-1:0] fmask;
  logic [N_FIELDS-1:0] feq;
  logic                hit;

  // Field order: 0 = minute, 1 = hour, 2 = day
  assign alm_arr[0] = alm_min;
  assign alm_arr[1] = alm_hour;
  assign alm_arr[2] = alm_day;
  assign cur_arr[0] = now_min;
  assign cur_arr[1] = now_hour;
  assign cur_arr[2] = now_day;

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
    tod_field_cmp #(.REG_W(REG_W)) u_cmp (
      .alarm_reg (alm_arr[g]),
      .cur_val   (cur_arr[g]),
      .mask      (fmask[g]),
      .eq        (feq[g])
    );
  end

  tod_mode_sel #(.N_FIELDS(N_FIELDS)) u_mode (
    .mask (fmask),
    .eq   (feq),
    .hit  (hit)
  );

  tod_alarm_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (upd_tick),
    .hit   (hit),
    .clr   (flag_clr),
    .flag  (tod_flag)
  );

  p_every_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_tick && alm_min[7] && alm_hour[7] && alm_day[7]) |=> tod_flag);
  p_full_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_tick && !alm_min[7] && !alm_hour[7] && !alm_day[7] &&
     alm_min[6:0] == now_min && alm_hour[6:0] == now_hour &&
     alm_day[6:0] == now_day) |=> tod_flag);
  p_bad_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tod_flag && !(alm_day[7] == alm_hour[7] && alm_hour[7] == alm_min[7]) &&
     !(alm_day[7] && alm_hour[7] && !alm_min[7]) &&
     !(alm_day[7] && !alm_hour[7] && !alm_min[7])) |=> !tod_flag);
endmodule

// File: tb/tb_tod_alarm_match.sv
module tb_tod_alarm_match;
  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic       rst_n, upd_tick, flag_clr, tod_flag;
  logic [6:0] now_min, now_hour, now_day;
  logic [7:0] alm_min, alm_hour, alm_day;

  int checks = 0;
  int errors = 0;

  tod_alarm_match dut (.*);

  // {alm_min, alm_hour, alm_day, now_min, now_hour, now_day, expected}
  localparam int NV = 10;
  localparam logic [45:0] VEC [NV] = '{
    {8'h80, 8'h80, 8'h80, 7'h12, 7'h03, 7'h06, 1'b1},  // all masked
    {8'h30, 8'h92, 8'h85, 7'h30, 7'h07, 7'h02, 1'b1},  // minute match
    {8'h30, 8'h92, 8'h85, 7'h31, 7'h12, 7'h05, 1'b0},  // minute miss
    {8'h45, 8'h09, 8'h83, 7'h45, 7'h09, 7'h06, 1'b1},  // hour+minute
    {8'h45, 8'h09, 8'h83, 7'h45, 7'h10, 7'h03, 1'b0},  // hour miss
    {8'h15, 8'h22, 8'h04, 7'h15, 7'h22, 7'h04, 1'b1},  // full match
    {8'h15, 8'h22, 8'h04, 7'h15, 7'h22, 7'h05, 1'b0},  // day miss
    {8'h59, 8'h23, 8'h07, 7'h59, 7'h23, 7'h07, 1'b1},  // top BCD values
    {8'h95, 8'h22, 8'h84, 7'h15, 7'h22, 7'h04, 1'b0},  // masks 101
    {8'h95, 8'hA2, 8'h04, 7'h15, 7'h22, 7'h04, 1'b0}   // masks 011
  };

  function automatic string vec_req(int i);
    case (i)
      0:       return "R2";
      1, 2:    return "R3";
      3, 4:    return "R4";
      5, 6:    return "R5";
      7:       return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: tod_flag actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic set_time(logic [7:0] am, logic [7:0] ah, logic [7:0] ad,
                          logic [6:0] nm, logic [6:0] nh, logic [6:0] nd);
    alm_min = am; alm_hour = ah; alm_day = ad;
    now_min = nm; now_hour = nh; now_day = nd;
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; upd_tick = 1'b0; flag_clr = 1'b0;
    set_time(8'h80, 8'h80, 8'h80, 7'h0, 7'h0, 7'h0);
    upd_tick = 1'b1;                       // tick during reset must not set
    repeat (3) @(negedge clk);
    check("R1", tod_flag, 1'b0);
    upd_tick = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", tod_flag, 1'b0);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      set_time(VEC[i][45:38], VEC[i][37:30], VEC[i][29:22],
               VEC[i][21:15], VEC[i][14:8], VEC[i][7:1]);
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      upd_tick = 1'b1;
      @(negedge clk);
      upd_tick = 1'b0;
      check(vec_req(i), tod_flag, VEC[i][0]);
    end

    // R6: full match held without a tick
    flag_clr = 1'b1;
    set_time(8'h15, 8'h22, 8'h04, 7'h15, 7'h22, 7'h04);
    @(negedge clk);
    flag_clr = 1'b0;
    repeat (3) @(negedge clk);
    check("R6", tod_flag, 1'b0);
    upd_tick = 1'b1;
    @(negedge clk);
    upd_tick = 1'b0;
    check("R6", tod_flag, 1'b1);

    // R7: sticky through non-matching ticks, then cleared
    now_min = 7'h16;
    upd_tick = 1'b1;
    repeat (2) @(negedge clk);
    upd_tick = 1'b0;
    check("R7", tod_flag, 1'b1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    check("R7", tod_flag, 0);
    @(negedge clk);
    check("R7", tod_flag, 1'b0);

    // R8: hit and clear together, flag low beforehand
    now_min = 7'h15;
    upd_tick = 1'b1; flag_clr = 1'b1;
    @(negedge clk);
    upd_tick = 1'b0; flag_clr = 1'b0;
    check("R8", tod_flag, 1'b1);
    // R8: hit and clear together, flag already high
    upd_tick = 1'b1; flag_clr = 1'b1;
    @(negedge clk);
    upd_tick = 1'b0; flag_clr = 1'b0;
    check("R8", tod_flag, 1'b1);

    // R2: every-minute mode re-fires after a clear
    set_time(8'h80, 8'h80, 8'h80, 7'h01, 7'h02, 7'h03);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    check("R2", tod_flag, 1'b0);
    upd_tick = 1'b1;
    @(negedge clk);
    upd_tick = 1'b0;
    check("R2", tod_flag, 1'b1);

    // R10: masks 010 and 001 never fire
    set_time(8'h95, 8'h22, 8'h84, 7'h15, 7'h22, 7'h04);   // 101 baseline cleared
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    set_time(8'h15, 8'hA2, 8'h04, 7'h15, 7'h22, 7'h04);   // {d,h,m} = 010
    upd_tick = 1'b1;
    @(negedge clk);
    check("R10", tod_flag, 1'b0);
    set_time(8'h95, 8'h22, 8'h04, 7'h15, 7'h22, 7'h04);   // {d,h,m} = 001
    @(negedge clk);
    upd_tick = 1'b0;
    check("R10", tod_flag, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule